// File: doc/BRIEF.md
# Shared Accelerator Ownership Arbiter

This block decides which of two masters may drive a single shared accelerator: an embedded processor subsystem or user fabric logic. It holds a small ownership state machine and steers the accelerator's write path and read-return path to the current owner only. Exactly one side, or during a handover neither side, is marked as owner on two flag outputs. When the fabric holds ownership its data path is open; otherwise the fabric sees a quiet, zeroed interface.

A two-bit configuration input, held static while out of reset, selects one of four modes. Two modes pin ownership to one side for good. The other two allow run-time handover and differ only in which side owns the accelerator after reset. A handover happens only when the current owner gives up the accelerator and the other side claims it in the same cycle. One idle cycle with no owner always separates the old owner from the new one.

Top module: `shared_accel_owner_arb`

## Requirements
- R1: The mode input encodes bit 1 as "shared" and bit 0 as "fabric is default owner". The values are 00 processor only, 01 fabric only, 10 shared with processor first, and 11 shared with fabric first. While reset is low, and in the first cycle after it, the owner flags show the mode's default owner.
- R2: In modes 00 and 01, the request and release inputs have no effect, and the owner flags never leave the default owner.
- R3: The processor-owner and fabric-owner flags are never high in the same cycle.
- R4: In a shared mode, if the processor owns the accelerator and a clock edge samples processor release=1, processor request=0, fabric request=1 and fabric release=0, then the processor flag drops after that edge and the fabric flag rises after the next edge.
- R5: In a shared mode, if the fabric owns the accelerator and a clock edge samples fabric release=1, fabric request=0, processor request=1 and processor release=0, then the fabric flag drops after that edge and the processor flag rises after the next edge.
- R6: Every handover has exactly one cycle with both owner flags low. The new owner follows regardless of the inputs in that cycle.
- R7: A request from the non-owner is held pending and leaves the owner flags unchanged while the owner has not yielded. Yielding means release high with request low.
- R8: While the fabric owns the accelerator, the accelerator write data and valid come from the fabric, and read data and valid are returned to the fabric. When the fabric does not own it, fabric read data is 0 and fabric read valid is 0.
- R9: While the processor owns the accelerator, the write path comes from the processor and reads return to the processor. When the processor does not own it, processor read data and valid are 0. With no owner, accelerator write data and valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgMode | input | 2 | Ownership mode, static while out of reset |
| procRequest | input | 1 | Processor wants or is using the accelerator |
| procRelease | input | 1 | Processor gives the accelerator up |
| fabRequest | input | 1 | Fabric wants or is using the accelerator |
| fabRelease | input | 1 | Fabric gives the accelerator up |
| procOwner | output | 1 | Processor currently owns the accelerator |
| fabOwner | output | 1 | Fabric owns the accelerator; fabric path enabled |
| procWrData | input | DATA_W | Processor write data toward accelerator |
| procWrValid | input | 1 | Processor write valid |
| fabWrData | input | DATA_W | Fabric write data toward accelerator |
| fabWrValid | input | 1 | Fabric write valid |
| accWrData | output | DATA_W | Write data delivered to the accelerator |
| accWrValid | output | 1 | Write valid delivered to the accelerator |
| accRdData | input | DATA_W | Read data from the accelerator |
| accRdValid | input | 1 | Read valid from the accelerator |
| procRdData | output | DATA_W | Read data returned to processor |
| procRdValid | output | 1 | Read valid returned to processor |
| fabRdData | output | DATA_W | Read data returned to fabric |
| fabRdValid | output | 1 | Read valid returned to fabric |

## Verification
The bench targets handover edge cases:
- A release that comes with the releasing side's request still high must not count as yielding. A design that only looks at release would hand over early.
- A claim that comes with the claimer's own release high must not be granted.
- A fixed mode that honours the handover inputs would move ownership away from its pinned owner.
- A design that grants in the same cycle as the release would raise both flags, or skip the gap cycle.
- A datapath gated by the wrong flag would leak write data to the accelerator during the gap, or return read data to the non-owner.

// File: rtl/owner_arb_pkg.sv
package owner_arb_pkg;

  // bit 1: shared, bit 0: fabric is default owner
  typedef enum logic [1:0] {
    MODE_PROC_ONLY   = 2'b00,
    MODE_FAB_ONLY    = 2'b01,
    MODE_SHARED_PROC = 2'b10,
    MODE_SHARED_FAB  = 2'b11
  } arbMode_e;

  typedef enum logic [1:0] {
    ST_PROC    = 2'b00,
    ST_FAB     = 2'b01,
    ST_TO_FAB  = 2'b10,
    ST_TO_PROC = 2'b11
  } ownState_e;

  typedef struct packed {
    logic procEn;
    logic fabEn;
  } pathStrobe_t;

  function automatic ownState_e defaultOwner(input logic [1:0] mode);
    return mode[0] ? ST_FAB : ST_PROC;
  endfunction

endpackage

// File: rtl/owner_arb_ctrl.sv
module owner_arb_ctrl
  import owner_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  cfgMode,
  input  logic        procRequest,
  input  logic        procRelease,
  input  logic        fabRequest,
  input  logic        fabRelease,
  output pathStrobe_t strobe,
  output logic        procOwner,
  output logic        fabOwner
);

  ownState_e state;
  ownState_e stateNxt;
  logic      sharedMode;
  logic      procYields;
  logic      procClaims;
  logic      fabYields;
  logic      fabClaims;

  assign sharedMode = cfgMode[1];
  assign procYields = procRelease & ~procRequest;
  assign procClaims = procRequest & ~procRelease;
  assign fabYields  = fabRelease & ~fabRequest;
  assign fabClaims  = fabRequest & ~fabRelease;

  always_comb begin
    stateNxt = state;
    if (!sharedMode) begin
      stateNxt = defaultOwner(cfgMode);
    end else begin
      unique case (state)
        ST_PROC:    if (procYields && fabClaims) stateNxt = ST_TO_FAB;
        ST_FAB:     if (fabYields && procClaims) stateNxt = ST_TO_PROC;
        ST_TO_FAB:  stateNxt = ST_FAB;
        ST_TO_PROC: stateNxt = ST_PROC;
        default:    stateNxt = defaultOwner(cfgMode);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= defaultOwner(cfgMode);
    else       state <= stateNxt;
  end

  assign procOwner     = (state == ST_PROC);
  assign fabOwner      = (state == ST_FAB);
  assign strobe.procEn = procOwner;
  assign strobe.fabEn  = fabOwner;

endmodule

// File: rtl/owner_arb_datapath.sv
module owner_arb_datapath
  import owner_arb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  pathStrobe_t       strobe,
  input  logic [DATA_W-1:0] procWrData,
  input  logic              procWrValid,
  input  logic [DATA_W-1:0] fabWrData,
  input  logic              fabWrValid,
  output logic [DATA_W-1:0] accWrData,
  output logic              accWrValid,
  input  logic [DATA_W-1:0] accRdData,
  input  logic              accRdValid,
  output logic [DATA_W-1:0] procRdData,
  output logic              procRdValid,
  output logic [DATA_W-1:0] fabRdData,
  output logic              fabRdValid
);

  localparam logic [DATA_W-1:0] ZERO = '0;

  always_comb begin
    accWrData  = ZERO;
    accWrValid = 1'b0;
    if (strobe.fabEn) begin
      accWrData  = fabWrData;
      accWrValid = fabWrValid;
    end else if (strobe.procEn) begin
      accWrData  = procWrData;
      accWrValid = procWrValid;
    end
  end

  assign fabRdData   = strobe.fabEn  ? accRdData : ZERO;
  assign fabRdValid  = strobe.fabEn  & accRdValid;
  assign procRdData  = strobe.procEn ? accRdData : ZERO;
  assign procRdValid = strobe.procEn & accRdValid;

endmodule

// File: rtl/shared_accel_owner_arb.sv
module shared_accel_owner_arb
  import owner_arb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgMode,
  input  logic              procRequest,
  input  logic              procRelease,
  input  logic              fabRequest,
  input  logic              fabRelease,
  output logic              procOwner,
  output logic              fabOwner,
  input  logic [DATA_W-1:0] procWrData,
  input  logic              procWrValid,
  input  logic [DATA_W-1:0] fabWrData,
  input  logic              fabWrValid,
  output logic [DATA_W-1:0] accWrData,
  output logic              accWrValid,
  input  logic [DATA_W-1:0] accRdData,
  input  logic              accRdValid,
  output logic [DATA_W-1:0] procRdData,
  output logic              procRdValid,
  output logic [DATA_W-1:0] fabRdData,
  output logic              fabRdValid
);

  pathStrobe_t strobe;

  owner_arb_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgMode     (cfgMode),
    .procRequest (procRequest),
    .procRelease (procRelease),
    .fabRequest  (fabRequest),
    .fabRelease  (fabRelease),
    .strobe      (strobe),
    .procOwner   (procOwner),
    .fabOwner    (fabOwner)
  );

  owner_arb_datapath #(.DATA_W(DATA_W)) u_path (
    .strobe      (strobe),
    .procWrData  (procWrData),
    .procWrValid (procWrValid),
    .fabWrData   (fabWrData),
    .fabWrValid  (fabWrValid),
    .accWrData   (accWrData),
    .accWrValid  (accWrValid),
    .accRdData   (accRdData),
    .accRdValid  (accRdValid),
    .procRdData  (procRdData),
    .procRdValid (procRdValid),
    .fabRdData   (fabRdData),
    .fabRdValid  (fabRdValid)
  );

endmodule

// File: rtl/owner_arb_checker.sv
module owner_arb_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] cfgMode,
  input logic       procRequest,
  input logic       procRelease,
  input logic       fabRequest,
  input logic       fabRelease,
  input logic       procOwner,
  input logic       fabOwner,
  input logic       accWrValid,
  input logic       fabRdValid,
  input logic       procRdValid
);

  p_mutex_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(procOwner && fabOwner));

  p_pin_proc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b00) |-> (procOwner && !fabOwner));

  p_pin_fab_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b01) |-> (fabOwner && !procOwner));

  p_to_fab_r4: assert property (@(posedge clk) disable iff (!rstN)
    (procOwner && cfgMode[1] && procRelease && !procRequest && fabRequest && !fabRelease)
      |=> (!procOwner && !fabOwner));

  p_to_proc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fabOwner && cfgMode[1] && fabRelease && !fabRequest && procRequest && !procRelease)
      |=> (!fabOwner && !procOwner));

  p_gap_fab_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(procOwner) |=> fabOwner);

  p_gap_proc_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fabOwner) |=> procOwner);

  p_hold_proc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (procOwner && !(procRelease && !procRequest)) |=> procOwner);

  p_hold_fab_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fabOwner && !(fabRelease && !fabRequest)) |=> fabOwner);

  p_fab_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !fabOwner |-> !fabRdValid);

  p_proc_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !procOwner |-> !procRdValid);

  p_gap_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!procOwner && !fabOwner) |-> !accWrValid);

endmodule

bind shared_accel_owner_arb owner_arb_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgMode     (cfgMode),
  .procRequest (procRequest),
  .procRelease (procRelease),
  .fabRequest  (fabRequest),
  .fabRelease  (fabRelease),
  .procOwner   (procOwner),
  .fabOwner    (fabOwner),
  .accWrValid  (accWrValid),
  .fabRdValid  (fabRdValid),
  .procRdValid (procRdValid)
);

// File: tb/shared_accel_owner_arb_bench.sv
`timescale 1ns/1ps
module shared_accel_owner_arb_bench;

  localparam int DATA_W = 32;
  localparam real CLK_HALF = 2.0;

  // model states
  localparam int M_PROC = 0, M_FAB = 1, M_TO_FAB = 2, M_TO_PROC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cfgMode = 2'b00;
  logic procRequest = 0, procRelease = 0, fabRequest = 0, fabRelease = 0;
  logic procOwner, fabOwner;
  logic [DATA_W-1:0] procWrData = '0, fabWrData = '0, accRdData = '0;
  logic procWrValid = 0, fabWrValid = 0, accRdValid = 0;
  logic [DATA_W-1:0] accWrData, procRdData, fabRdData;
  logic accWrValid, procRdValid, fabRdValid;

  int total = 0;
  int bad = 0;
  int model = M_PROC;
  int prevModel = M_PROC;
  bit done = 0;

  always #(CLK_HALF) clk = ~clk;

  shared_accel_owner_arb #(.DATA_W(DATA_W)) u_shared_accel_owner_arb (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode),
    .procRequest(procRequest), .procRelease(procRelease),
    .fabRequest(fabRequest), .fabRelease(fabRelease),
    .procOwner(procOwner), .fabOwner(fabOwner),
    .procWrData(procWrData), .procWrValid(procWrValid),
    .fabWrData(fabWrData), .fabWrValid(fabWrValid),
    .accWrData(accWrData), .accWrValid(accWrValid),
    .accRdData(accRdData), .accRdValid(accRdValid),
    .procRdData(procRdData), .procRdValid(procRdValid),
    .fabRdData(fabRdData), .fabRdValid(fabRdValid)
  );

  function automatic int defaultState(input logic [1:0] md);
    return md[0] ? M_FAB : M_PROC;
  endfunction

  function automatic int nextState(input int st, input logic [1:0] md,
                                   input logic pRq, input logic pRl,
                                   input logic fRq, input logic fRl);
    if (!md[1]) return defaultState(md);
    case (st)
      M_PROC:    return (pRl && !pRq && fRq && !fRl) ? M_TO_FAB : M_PROC;
      M_FAB:     return (fRl && !fRq && pRq && !pRl) ? M_TO_PROC : M_FAB;
      M_TO_FAB:  return M_FAB;
      default:   return M_PROC;
    endcase
  endfunction

  function automatic string ownerTag();
    if (!cfgMode[1])             return "R2";
    if (model == M_TO_FAB || model == M_TO_PROC) return "R6";
    if (prevModel == M_TO_FAB)   return "R4";
    if (prevModel == M_TO_PROC)  return "R5";
    return "R7";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string ownTag);
    logic [DATA_W-1:0] eWd, eFr, ePr;
    logic eWv, eFv, ePv;
    check(ownTag, "procOwner", DATA_W'(procOwner), DATA_W'(model == M_PROC));
    check(ownTag, "fabOwner",  DATA_W'(fabOwner),  DATA_W'(model == M_FAB));
    check("R3", "bothOwners", DATA_W'(procOwner & fabOwner), '0);
    eWd = (model == M_FAB) ? fabWrData : (model == M_PROC) ? procWrData : '0;
    eWv = (model == M_FAB) ? fabWrValid : (model == M_PROC) ? procWrValid : 1'b0;
    eFr = (model == M_FAB) ? accRdData : '0;
    eFv = (model == M_FAB) & accRdValid;
    ePr = (model == M_PROC) ? accRdData : '0;
    ePv = (model == M_PROC) & accRdValid;
    check((model == M_FAB) ? "R8" : "R9", "accWrData", accWrData, eWd);
    check((model == M_FAB) ? "R8" : "R9", "accWrValid", DATA_W'(accWrValid), DATA_W'(eWv));
    check("R8", "fabRdData", fabRdData, eFr);
    check("R8", "fabRdValid", DATA_W'(fabRdValid), DATA_W'(eFv));
    check("R9", "procRdData", procRdData, ePr);
    check("R9", "procRdValid", DATA_W'(procRdValid), DATA_W'(ePv));
  endtask

  // called at a falling edge; drives inputs, advances one cycle, checks
  task automatic runCycle(input logic pRq, input logic pRl,
                          input logic fRq, input logic fRl);
    int nxt;
    procRequest = pRq; procRelease = pRl;
    fabRequest  = fRq; fabRelease  = fRl;
    procWrData  = $urandom; fabWrData = $urandom; accRdData = $urandom;
    procWrValid = 1'($urandom); fabWrValid = 1'($urandom); accRdValid = 1'($urandom);
    nxt = nextState(model, cfgMode, pRq, pRl, fRq, fRl);
    @(posedge clk);
    prevModel = model;
    model = nxt;
    @(negedge clk);
    checkAll(ownerTag());
  endtask

  task automatic doReset(input logic [1:0] md);
    @(negedge clk);
    rstN = 1'b0;
    cfgMode = md;
    procRequest = 0; procRelease = 0; fabRequest = 0; fabRelease = 0;
    repeat (3) @(negedge clk);
    model = defaultState(md);
    prevModel = model;
    check("R1", "procOwner in reset", DATA_W'(procOwner), DATA_W'(!md[0]));
    check("R1", "fabOwner in reset",  DATA_W'(fabOwner),  DATA_W'(md[0]));
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));

    // directed: shared, processor first
    doReset(2'b10);
    repeat (3) runCycle(1, 0, 1, 0);      // pending fabric claim, R7
    runCycle(1, 1, 1, 0);                 // release with request high: not a yield, R7
    runCycle(0, 1, 1, 1);                 // claimer also releasing: no grant, R7
    runCycle(0, 1, 1, 0);                 // yield + claim: gap, R6
    runCycle(1, 0, 1, 0);                 // fabric granted, R4
    repeat (3) runCycle(1, 0, 1, 0);      // pending processor claim, R7
    runCycle(1, 0, 0, 1);                 // gap, R6
    runCycle(0, 0, 0, 0);                 // processor granted, R5

    // directed: fixed modes ignore handover, R2
    doReset(2'b00);
    repeat (4) runCycle(0, 1, 1, 0);
    doReset(2'b01);
    repeat (4) runCycle(1, 0, 0, 1);

    // directed: shared, fabric first
    doReset(2'b11);
    runCycle(1, 0, 0, 1);
    runCycle(0, 0, 0, 0);
    runCycle(0, 1, 1, 0);
    runCycle(0, 0, 0, 0);

    // random in every mode
    for (int m = 0; m < 4; m++) begin
      doReset(2'(m));
      for (int i = 0; i < 1500; i++)
        runCycle(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4.0 * 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule